// File: doc/BRIEF.md
# Page Write Load Controller

This block is the write side of a byte-wide nonvolatile memory that has a synchronous SRAM-like interface. Byte writes are collected in a 64-byte page latch. The first write of a load captures the page number. Later writes to the same page fill more bytes in any order, and a byte written twice keeps its latest value. Each byte must follow the previous accepted byte within a byte-load window. When the window passes with no new byte, loading ends and a programming period of fixed length begins.

During programming the controller walks a per-byte valid mask. Only the bytes that were loaded are copied into the backing array, so the rest of the page keeps its old contents. The block reports a busy flag while programming and ignores writes during that time. It also holds the address of the most recently accepted byte. A sticky error flag is set when a write targets a page other than the one being loaded. A registered read port returns array contents.

The window length and the programming time are parameters counted in clock cycles. The default array is 2048 bytes (11 address bits: 6 byte bits and 5 page bits), so that the block elaborates at a modest size.

Top module: `pw_page_ctrl`

## Requirements
- R1: After a synchronous active-low reset, busy is 0, page_error is 0 and last_addr is 0.
- R2: Address bits [5:0] select the byte within a page and the remaining upper bits select the page. The page is captured from the first write of a load.
- R3: A load ends when WINDOW_CYC clock edges pass with no accepted byte. busy is high after the edge WINDOW_CYC cycles after the last accepted byte. A byte that arrives exactly WINDOW_CYC edges after the previous one is still accepted and restarts the window.
- R4: Within a load, bytes may arrive in any order and a byte may be rewritten. The last value written is the one that is programmed.
- R5: Only the bytes loaded in the current load are written to the array. Every other byte of that page keeps its previous value.
- R6: During a load, a write whose page bits differ from the captured page is ignored: last_addr and the window do not change. It sets page_error, which stays at 1 until reset.
- R7: busy stays high for exactly PROG_CYC cycles and then returns to 0. After that, a new write starts a new load.
- R8: A write presented while busy is high is ignored: last_addr and the array do not change.
- R9: last_addr equals the address of the most recently accepted byte, one cycle after that byte is accepted.
- R10: rd_data shows the array byte at rd_addr one cycle after rd_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W | Byte write address |
| wr_data | input | 8 | Byte write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Programming in progress |
| last_addr | output | ADDR_W | Address of last accepted byte |
| page_error | output | 1 | Sticky foreign-page write flag |

## Verification
A write is sampled at a rising edge. last_addr and page_error change at that same edge, so the bench checks them at the following falling edge. busy must still be low at the falling edge WINDOW_CYC-1 cycles after the last accepted byte and high one cycle later. It must still be high PROG_CYC-1 falling edges after that and low at the next one. A read result is due one edge after the address. The bench drives and samples only on falling edges, and it counts these waits exactly instead of polling, except where it waits for the end of a period whose timing it has already measured.

// File: rtl/pw_pkg.sv
// Shared types for the page write load controller.
package pw_pkg;
    // Controller phase: waiting, collecting bytes, programming the array.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_t;
endpackage

// File: rtl/pw_page_latch.sv
// Page latch: one data byte and one valid bit per byte of the page.
// Assumes that start and load are never high in the same cycle as a
// commit read that needs stable data (the sequencer guarantees this).
module pw_page_latch #(
    parameter int OFF_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  load,
    input  logic [OFF_W-1:0]      off,
    input  logic [DATA_W-1:0]     din,
    input  logic [OFF_W-1:0]      rd_idx,
    output logic [DATA_W-1:0]     rd_byte,
    output logic [(1<<OFF_W)-1:0] mask
);
    localparam int NB = 1 << OFF_W;

    logic [DATA_W-1:0] bytes_q [NB];

    // Store the data byte; a later write to the same slot replaces it.
    always_ff @(posedge clk) begin
        if (start || load)
            bytes_q[off] <= din;
    end

    // The valid mask is cleared to the one new byte at load start and extended per byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (start)
            mask <= NB'(1) << off;
        else if (load)
            mask[off] <= 1'b1;
    end

    assign rd_byte = bytes_q[rd_idx];

    // R4: a fresh load always begins with exactly one valid byte
    assert_fresh_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ($countones(mask) == 1));
endmodule

// File: rtl/pw_array.sv
// Backing array: synchronous write port and registered read port.
// Assumes no reset of the contents (nonvolatile model).
module pw_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Write one committed byte.
    always_ff @(posedge clk) begin
        if (we)
            cells[waddr] <= wdata;
    end

    // Registered read.
    always_ff @(posedge clk) begin
        rdata <= cells[raddr];
    end
endmodule

// File: rtl/pw_load_seq.sv
// Load sequencer: captures the page, times the byte-load window, runs the
// programming period and walks the valid mask to commit loaded bytes.
// Assumes PROG_CYC >= number of bytes per page, so the walk fits the period.
module pw_load_seq
    import pw_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int OFF_W      = 6,
    parameter int WINDOW_CYC = 15000,
    parameter int PROG_CYC   = 1000000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [(1<<OFF_W)-1:0] mask,
    output logic                  start,
    output logic                  load,
    output logic                  commit_we,
    output logic [OFF_W-1:0]      commit_idx,
    output logic [ADDR_W-1:0]     commit_addr,
    output logic                  busy,
    output logic [ADDR_W-1:0]     last_addr,
    output logic                  page_error
);
    localparam int PG_W  = ADDR_W - OFF_W;
    localparam int NB    = 1 << OFF_W;
    localparam int LIMIT = (PROG_CYC > WINDOW_CYC) ? PROG_CYC : WINDOW_CYC;
    localparam int CW    = $clog2(LIMIT + 1);

    phase_t          ph;
    logic [CW-1:0]   cnt;
    logic [PG_W-1:0] page_q;
    logic            same_page;
    logic            in_walk;

    assign same_page   = (wr_addr[ADDR_W-1:OFF_W] == page_q);
    assign start       = wr_en && (ph == PH_IDLE);
    assign load        = wr_en && (ph == PH_LOAD) && same_page;
    assign busy        = (ph == PH_PROG);
    assign in_walk     = busy && (cnt < CW'(NB));
    assign commit_idx  = cnt[OFF_W-1:0];
    assign commit_we   = in_walk && mask[commit_idx];
    assign commit_addr = {page_q, commit_idx};

    // Phase and shared counter: window timer while loading, period timer while programming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (wr_en) begin
                    ph  <= PH_LOAD;
                    cnt <= '0;
                end
                PH_LOAD: if (load) begin
                    cnt <= '0;
                end else if (cnt == CW'(WINDOW_CYC - 1)) begin
                    ph  <= PH_PROG;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                PH_PROG: if (cnt == CW'(PROG_CYC - 1)) begin
                    ph  <= PH_IDLE;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Page capture, last accepted address and sticky foreign-page flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q     <= '0;
            last_addr  <= '0;
            page_error <= 1'b0;
        end else begin
            if (start)
                page_q <= wr_addr[ADDR_W-1:OFF_W];
            if (start || load)
                last_addr <= wr_addr;
            if (wr_en && (ph == PH_LOAD) && !same_page)
                page_error <= 1'b1;
        end
    end

    // Checker state: length of the current busy run.
    logic [CW:0] busy_run;
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_run <= '0;
        else if (busy)
            busy_run <= busy_run + 1'b1;
        else
            busy_run <= '0;
    end

    // R7: programming lasts exactly PROG_CYC cycles
    assert_prog_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == (CW+1)'(PROG_CYC)));

    // R6: a foreign-page write sets the flag and leaves the load untouched
    assert_foreign_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (ph == PH_LOAD) && !same_page) |=> (page_error && $stable(last_addr)));

    // R6: the flag is sticky
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        page_error |=> page_error);
endmodule

// File: rtl/pw_page_ctrl.sv
// Top: page write load controller. Byte writes fill a page latch; after a
// byte-load inactivity window the loaded bytes are committed to the array
// during a fixed programming period. Assumes PROG_CYC >= 2**OFF_W.
module pw_page_ctrl #(
    parameter int ADDR_W     = 11,
    parameter int OFF_W      = 6,
    parameter int DATA_W     = 8,
    parameter int WINDOW_CYC = 15000,
    parameter int PROG_CYC   = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic [ADDR_W-1:0] last_addr,
    output logic              page_error
);
    localparam int NB = 1 << OFF_W;

    logic              start, load, commit_we;
    logic [OFF_W-1:0]  commit_idx;
    logic [ADDR_W-1:0] commit_addr;
    logic [NB-1:0]     mask;
    logic [DATA_W-1:0] commit_byte;

    pw_load_seq #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W),
        .WINDOW_CYC(WINDOW_CYC), .PROG_CYC(PROG_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .mask(mask),
        .start(start), .load(load), .commit_we(commit_we), .commit_idx(commit_idx),
        .commit_addr(commit_addr), .busy(busy), .last_addr(last_addr),
        .page_error(page_error)
    );

    pw_page_latch #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .start(start), .load(load),
        .off(wr_addr[OFF_W-1:0]), .din(wr_data), .rd_idx(commit_idx),
        .rd_byte(commit_byte), .mask(mask)
    );

    pw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .we(commit_we), .waddr(commit_addr), .wdata(commit_byte),
        .raddr(rd_addr), .rdata(rd_data)
    );

    // R8: a write during programming leaves last_addr unchanged
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> $stable(last_addr));

    // R3: programming only begins on a cycle with no accepted byte
    assert_quiet_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(load));

    // R9: an accepted byte's address shows on last_addr next cycle
    assert_last_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start || load) |=> (last_addr == $past(wr_addr)));
endmodule

// File: tb/sim_pw_page_ctrl.sv
module sim_pw_page_ctrl;
    localparam int AW = 11;
    localparam int W  = 8;
    localparam int P  = 80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy, page_error;
    logic [AW-1:0] last_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    pw_page_ctrl #(.ADDR_W(AW), .OFF_W(6), .DATA_W(8), .WINDOW_CYC(W), .PROG_CYC(P)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .last_addr(last_addr),
        .page_error(page_error)
    );

    // Second load, all in page 3: {foreign page, addr, data}.
    localparam logic [19:0] LOAD_V [6] = '{
        {1'b0, 11'h0C5, 8'hA1},
        {1'b0, 11'h0C2, 8'hB2},
        {1'b1, 11'h1C5, 8'h77},
        {1'b0, 11'h0C5, 8'hC3},
        {1'b0, 11'h0FE, 8'hD4},
        {1'b0, 11'h0C0, 8'hE5}
    };
    // Expected array contents after the second load: {addr, data}.
    localparam logic [18:0] RB_V [7] = '{
        {11'h0C0, 8'hE5}, {11'h0C1, 8'h11}, {11'h0C2, 8'hB2}, {11'h0C5, 8'hC3},
        {11'h0C6, 8'h16}, {11'h0FE, 8'hD4}, {11'h0FF, 8'h4F}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; the write is sampled at the next rising edge.
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        rd_addr = a;
        @(negedge clk);
        check(req, {24'd0, rd_data}, {24'd0, exp});
    endtask

    // Called right after the last accepted write returns.
    task automatic expect_commit(input string req);
        repeat (W-1) @(negedge clk);
        check({req, " R3 still loading"}, {31'd0, busy}, 32'd0);
        @(negedge clk);
        check({req, " R3 window expired"}, {31'd0, busy}, 32'd1);
        repeat (P-1) @(negedge clk);
        check({req, " R7 busy held"}, {31'd0, busy}, 32'd1);
        @(negedge clk);
        check({req, " R7 busy cleared"}, {31'd0, busy}, 32'd0);
    endtask

    initial begin
        int guard;
        logic [AW-1:0] exp_last;
        repeat (3) @(negedge clk);
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 page_error", {31'd0, page_error}, 32'd0);
        check("R1 last_addr", {21'd0, last_addr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Load 1: fill page 3 (R2) with data 0x10+i, in order.
        for (int i = 0; i < 64; i++) wr(AW'(11'h0C0 + i), 8'(8'h10 + i));
        check("R9 last_addr after full page", {21'd0, last_addr}, 32'h0FF);
        expect_commit("load1");

        // Load 2: table walk, any order, overwrite, one foreign page (R4, R6, R9).
        exp_last = '0;
        for (int i = 0; i < 6; i++) begin
            wr(LOAD_V[i][18:8], LOAD_V[i][7:0]);
            if (!LOAD_V[i][19]) exp_last = LOAD_V[i][18:8];
            check("R9/R6 last_addr in load", {21'd0, last_addr}, {21'd0, exp_last});
            check("R6 page_error", {31'd0, page_error},
                  {31'd0, (i >= 2) ? 1'b1 : 1'b0});
        end
        expect_commit("load2");
        for (int i = 0; i < 7; i++) rd("R4/R5/R10 readback", RB_V[i][18:8], RB_V[i][7:0]);

        // R7 new load after programming, R8 write while busy is ignored.
        wr(11'h005, 8'h99);
        check("R7 new load accepted", {21'd0, last_addr}, 32'h005);
        repeat (W) @(negedge clk);
        check("R8 busy before ignored write", {31'd0, busy}, 32'd1);
        wr(11'h0C1, 8'h00);
        check("R8 last_addr unchanged", {21'd0, last_addr}, 32'h005);
        guard = 0;
        while (busy && guard < 4*P) begin
            @(negedge clk);
            guard++;
        end
        rd("R8 array unchanged", 11'h0C1, 8'h11);
        rd("R5 new byte programmed", 11'h005, 8'h99);

        // R3 boundary: second byte exactly W edges after the first is accepted.
        wr(11'h011, 8'h21);
        repeat (W-1) @(negedge clk);
        wr(11'h012, 8'h22);
        check("R3 byte at window edge accepted", {21'd0, last_addr}, 32'h012);
        expect_commit("boundary");
        rd("R3 first byte", 11'h011, 8'h21);
        rd("R3 edge byte", 11'h012, 8'h22);
        check("R6 page_error sticky", {31'd0, page_error}, 32'd1);

        // R1 reset again.
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset busy", {31'd0, busy}, 32'd0);
        check("R1 reset page_error", {31'd0, page_error}, 32'd0);
        check("R1 reset last_addr", {21'd0, last_addr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule